// File: doc/BRIEF.md
# ATA Device Interrupt Request Logic

This block produces the host interrupt line of an ATA-style storage device. It keeps one pending-interrupt bit that internal events raise: the end of a command, and the start of each PIO data block. The line is driven only while the host has interrupts enabled and the drive-select setting points at this device. Otherwise the pad is left floating, which appears here as a low output-enable.

Several host accesses remove the pending bit as a side effect: a read of the status register, any write to the command register, a write to the device control register with the software-reset bit set, and hardware reset. If a clear and a set arrive in the same cycle, the clear wins.

A block tracker decides which sector boundaries start a new data block. A block is one sector unless the command runs in multiple mode with a non-zero block count configured earlier. Write-class commands (format track, write sectors, write buffer, write long) get no interrupt at the start of their first block. The command decoder outside this block flags that class. Command execution, data movement and the pad cells are not part of this block.

Top module: `ata_irq_ctrl`

## Requirements
- R1: After reset the pending bit is clear, interrupts are enabled, the select setting is 0 and no transfer is active. With the default identity of 0, `irq_o`=0 and `irq_oe_o`=1.
- R2: `irq_o` is 1 only when the pending bit is set and `irq_oe_o` is 1.
- R3: `irq_oe_o` is 0 and `irq_o` is 0 when the last control write had `ctl_nien_i`=1, or the last select write differs from parameter `DEV_ID`.
- R4: A pulse on `cmd_done_i` sets the pending bit. It is visible on `irq_o` in the cycle after the edge that samples the pulse.
- R5: A cycle with `status_rd_i`=1 clears the pending bit.
- R6: A cycle with `cmd_wr_i`=1 clears the pending bit and ends any active transfer.
- R7: A control write with `ctl_srst_i`=1 clears the pending bit. A control write with `ctl_srst_i`=0 leaves it unchanged.
- R8: When a clear and a set fall in the same cycle, the pending bit ends up clear.
- R9: `xfer_start_i` sets the pending bit when `xfer_wclass_i`=0 and leaves it unchanged when `xfer_wclass_i`=1.
- R10: During a transfer, the block length is the stored multiple count when `xfer_multi_i` was 1 at start and that count is non-zero; otherwise it is 1. The sector pulse that completes a block sets the pending bit, unless it is marked last.
- R11: A sector pulse with `sector_last_i`=1 sets no pending bit and ends the transfer. Later sector pulses then have no effect.
- R12: Disabling the line or deselecting the device does not clear the pending bit. Once the line is enabled and selected again, `irq_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| ctl_wr_i | input | 1 | Host write strobe to the device control register |
| ctl_nien_i | input | 1 | Interrupt-disable bit of that write |
| ctl_srst_i | input | 1 | Software-reset bit of that write |
| dev_wr_i | input | 1 | Host write strobe to the drive/head register |
| dev_sel_i | input | 1 | Drive-select bit of that write |
| cmd_wr_i | input | 1 | Host write to the command register |
| status_rd_i | input | 1 | Host read of the status register |
| cmd_done_i | input | 1 | Command completion event |
| mult_set_i | input | 1 | Stores a new multiple block count |
| mult_cnt_i | input | CNT_W | Sectors per block for multiple mode (0 = off) |
| xfer_start_i | input | 1 | PIO data phase begins |
| xfer_wclass_i | input | 1 | Starting command is write-class |
| xfer_multi_i | input | 1 | Starting command uses multiple mode |
| sector_done_i | input | 1 | One sector transferred |
| sector_last_i | input | 1 | Qualifies sector_done_i as the final sector |
| irq_o | output | 1 | Interrupt value driven to the pad |
| irq_oe_o | output | 1 | Pad output enable; 0 means high impedance |

## Verification
The assertions assume every event input is a single-cycle pulse. They also assume sector pulses come only after a transfer start and that `mult_cnt_i` changes only through `mult_set_i`. The directed stimulus drives each strobe for one cycle between falling edges and returns it to 0. Collisions occur only where the priority rule is under test. The multiple count is programmed before the transfer that uses it, so a block counter never runs past its latched length.

// File: rtl/ata_irq_pkg.sv
package ata_irq_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_FIRST  = 2'd1,
    EV_BLOCK  = 2'd2,
    EV_END    = 2'd3
  } blk_ev_e;

  function automatic logic [15:0] blk_len(input logic multi, input logic [15:0] cnt);
    return (multi && cnt != '0) ? cnt : 16'd1;
  endfunction
endpackage

// File: rtl/ata_irq_regs.sv
module ata_irq_regs #(
  parameter bit DEV_ID = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_wr_i,
  input  logic ctl_nien_i,
  input  logic ctl_srst_i,
  input  logic dev_wr_i,
  input  logic dev_sel_i,
  output logic srst_o,
  output logic drive_en_o
);
  logic nien_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nien_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      if (ctl_wr_i) nien_q <= ctl_nien_i;
      if (dev_wr_i) sel_q  <= dev_sel_i;
    end
  end

  assign srst_o     = ctl_wr_i & ctl_srst_i;
  assign drive_en_o = !nien_q && (sel_q == DEV_ID);

  // R3
  nien_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr_i && !dev_wr_i |=> $stable(drive_en_o));
endmodule

// File: rtl/ata_irq_pend.sv
module ata_irq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (clr_i)  pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

  // R8
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_q);
  // R4
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !clr_i |=> pend_q);
  // R12
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i |=> $stable(pend_q));
endmodule

// File: rtl/ata_irq_blk.sv
module ata_irq_blk
  import ata_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             mult_set_i,
  input  logic [CNT_W-1:0] mult_cnt_i,
  input  logic             xfer_start_i,
  input  logic             xfer_wclass_i,
  input  logic             xfer_multi_i,
  input  logic             sector_done_i,
  input  logic             sector_last_i,
  output logic             blk_irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] mult_q, len_q, cnt_q, cnt_nxt, len_nxt;
  logic             act_q, at_bound;
  blk_ev_e          ev;

  assign cnt_nxt  = cnt_q + ONE;
  assign len_nxt  = (xfer_multi_i && mult_q != '0) ? mult_q : ONE;
  assign at_bound = (cnt_nxt == len_q);

  always_comb begin
    ev = EV_NONE;
    if (xfer_start_i && !xfer_wclass_i)          ev = EV_FIRST;
    else if (act_q && sector_done_i) begin
      if (sector_last_i)                          ev = EV_END;
      else if (at_bound)                          ev = EV_BLOCK;
    end
  end

  assign blk_irq_o = (ev == EV_FIRST) || (ev == EV_BLOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mult_q <= '0;
      len_q  <= ONE;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      if (mult_set_i) mult_q <= mult_cnt_i;
      if (abort_i) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (xfer_start_i) begin
        act_q <= 1'b1;
        cnt_q <= '0;
        len_q <= len_nxt;
      end else if (act_q && sector_done_i) begin
        if (sector_last_i) begin
          act_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= at_bound ? '0 : cnt_nxt;
        end
      end
    end
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < len_q);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q && !xfer_start_i |-> !blk_irq_o);
  // R9
  wclass_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_i && xfer_wclass_i && !act_q |-> !blk_irq_o);
endmodule

// File: rtl/ata_irq_ctrl.sv
module ata_irq_ctrl
  import ata_irq_pkg::*;
#(
  parameter bit DEV_ID = 1'b0,
  parameter int CNT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic             ctl_nien_i,
  input  logic             ctl_srst_i,
  input  logic             dev_wr_i,
  input  logic             dev_sel_i,
  input  logic             cmd_wr_i,
  input  logic             status_rd_i,
  input  logic             cmd_done_i,
  input  logic             mult_set_i,
  input  logic [CNT_W-1:0] mult_cnt_i,
  input  logic             xfer_start_i,
  input  logic             xfer_wclass_i,
  input  logic             xfer_multi_i,
  input  logic             sector_done_i,
  input  logic             sector_last_i,
  output logic             irq_o,
  output logic             irq_oe_o
);
  logic srst, drive_en, blk_irq, pend, clr, set;

  ata_irq_regs #(.DEV_ID(DEV_ID)) i_regs (
    .clk_i, .rst_ni, .ctl_wr_i, .ctl_nien_i, .ctl_srst_i,
    .dev_wr_i, .dev_sel_i, .srst_o(srst), .drive_en_o(drive_en)
  );

  ata_irq_blk #(.CNT_W(CNT_W)) i_blk (
    .clk_i, .rst_ni, .abort_i(cmd_wr_i | srst), .mult_set_i, .mult_cnt_i,
    .xfer_start_i, .xfer_wclass_i, .xfer_multi_i,
    .sector_done_i, .sector_last_i, .blk_irq_o(blk_irq)
  );

  assign clr = srst | cmd_wr_i | status_rd_i;
  assign set = cmd_done_i | blk_irq;

  ata_irq_pend i_pend (
    .clk_i, .rst_ni, .set_i(set), .clr_i(clr), .pend_o(pend)
  );

  assign irq_oe_o = drive_en;
  assign irq_o    = pend & drive_en;

  // R2
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_oe_o && pend);
  // R5
  status_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> !irq_o);
endmodule

// File: tb/test_ata_irq_ctrl.sv
module test_ata_irq_ctrl;
  localparam int CNT_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ctl_wr_i = 0, ctl_nien_i = 0, ctl_srst_i = 0, dev_wr_i = 0, dev_sel_i = 0;
  logic cmd_wr_i = 0, status_rd_i = 0, cmd_done_i = 0, mult_set_i = 0;
  logic [CNT_W-1:0] mult_cnt_i = '0;
  logic xfer_start_i = 0, xfer_wclass_i = 0, xfer_multi_i = 0;
  logic sector_done_i = 0, sector_last_i = 0;
  logic irq_o, irq_oe_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  ata_irq_ctrl #(.DEV_ID(1'b0), .CNT_W(CNT_W)) i_ata_irq_ctrl (.*);

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    ctl_wr_i = 0; dev_wr_i = 0; cmd_wr_i = 0; status_rd_i = 0; cmd_done_i = 0;
    mult_set_i = 0; xfer_start_i = 0; sector_done_i = 0; sector_last_i = 0;
  endtask

  task automatic ctl(input logic nien, input logic srst);
    ctl_wr_i = 1; ctl_nien_i = nien; ctl_srst_i = srst; step();
  endtask
  task automatic dev(input logic s); dev_wr_i = 1; dev_sel_i = s; step(); endtask
  task automatic rd_status(); status_rd_i = 1; step(); endtask
  task automatic done(); cmd_done_i = 1; step(); endtask
  task automatic start(input logic wc, input logic mu);
    xfer_start_i = 1; xfer_wclass_i = wc; xfer_multi_i = mu; step();
  endtask
  task automatic sector(input logic last);
    sector_done_i = 1; sector_last_i = last; step();
  endtask
  task automatic set_mult(input int n);
    mult_set_i = 1; mult_cnt_i = CNT_W'(n); step();
  endtask

  task automatic t_reset();
    chk(irq_o, 0, "R1 irq after reset");
    chk(irq_oe_o, 1, "R1 oe after reset");
    sector(0);
    chk(irq_o, 0, "R1 no transfer active after reset");
  endtask

  task automatic t_clears();
    done();       chk(irq_o, 1, "R4 cmd_done sets");
    rd_status();  chk(irq_o, 0, "R5 status read clears");
    done();       cmd_wr_i = 1; step(); chk(irq_o, 0, "R6 command write clears");
    done();       ctl(0, 0);    chk(irq_o, 1, "R7 ctl write without srst keeps");
    ctl(0, 1);    chk(irq_o, 0, "R7 srst clears");
    ctl(0, 0);
  endtask

  task automatic t_gate();
    done();
    ctl(1, 0);
    chk(irq_oe_o, 0, "R3 nien floats line");
    chk(irq_o, 0, "R2 irq low while disabled");
    ctl(0, 0);    chk(irq_o, 1, "R12 pending survives nien");
    dev(1);
    chk(irq_oe_o, 0, "R3 other drive selected");
    chk(irq_o, 0, "R2 irq low while deselected");
    dev(0);       chk(irq_o, 1, "R12 pending survives deselect");
    rd_status();
  endtask

  task automatic t_prio();
    cmd_done_i = 1; status_rd_i = 1; step();
    chk(irq_o, 0, "R8 clear beats set");
    xfer_start_i = 1; xfer_wclass_i = 0; xfer_multi_i = 0; cmd_wr_i = 1; step();
    chk(irq_o, 0, "R8 command write beats first-block set");
  endtask

  task automatic t_read_single();
    start(0, 0);   chk(irq_o, 1, "R9 read first block");
    rd_status();
    sector(0);     chk(irq_o, 1, "R10 single-sector block");
    rd_status();
    sector(1);     chk(irq_o, 0, "R11 last sector no irq");
    sector(0);     chk(irq_o, 0, "R11 pulse after end ignored");
  endtask

  task automatic t_write_single();
    start(1, 0);   chk(irq_o, 0, "R9 write-class first block suppressed");
    sector(0);     chk(irq_o, 1, "R10 write second block");
    rd_status();
    sector(1);     chk(irq_o, 0, "R11 write last sector");
  endtask

  task automatic t_multi();
    set_mult(3);
    start(0, 1);   chk(irq_o, 1, "R9 multi first block");
    rd_status();
    sector(0);     chk(irq_o, 0, "R10 mid block sector 1");
    sector(0);     chk(irq_o, 0, "R10 mid block sector 2");
    sector(0);     chk(irq_o, 1, "R10 block of 3 complete");
    rd_status();
    sector(0); sector(0);
    sector(1);     chk(irq_o, 0, "R11 last sector in multi");
    start(1, 0);   sector(0);
    chk(irq_o, 1, "R10 non-multi command ignores count");
    rd_status();   sector(1);
    set_mult(0);
    start(0, 1);   rd_status();
    sector(0);     chk(irq_o, 1, "R10 zero count means one sector");
    rd_status();   sector(1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_clears();
    t_gate();
    t_prio();
    t_read_single();
    t_write_single();
    t_multi();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule